// File: doc/BRIEF.md
# Dual-Lane Instruction Window with Hazard Control

This block sits between instruction fetch and two execution lanes: an integer lane, whose result can be forwarded to a consumer issued in the very next cycle, and a floating-point lane, whose result can only be forwarded from its fourth execute stage. Each cycle the block can take in one fetched instruction and place it in a small window. In the same cycle it can issue up to two instructions from the window, one to each lane. Within each lane the choice is made by age among the entries that are ready, so a younger independent instruction can overtake an older one that is waiting on an operand.

The block enforces the data hazards itself:
- **RAW.** Every source is compared against older window entries that are still unissued and against floating-point results not yet forwardable.
- **WAW.** An incoming instruction whose destination collides with a pending writer is refused at the fetch boundary.
- **WAR.** A writer is held until all older readers of its destination have issued.

A branch that enters the window freezes fetch until the branch itself issues. The register file and the execution lanes are outside the block. Fetch sees only a single stall output, and it must hold its instruction steady while that output is high.

Top module: `iw_dispatch`

## Requirements
- R1: After reset the window and the floating-point tracking stages are empty, neither lane issues, and `fetch_stall` is low while `in_valid` is low.
- R2: Class code 0 is an integer operation and goes to the integer lane. Code 1 is a floating-point operation and goes to the floating-point lane. Code 2 is a branch: it goes to the integer lane with `int_is_br` high and writes no register. An issued instruction carries its destination and both source indices unchanged.
- R3: In each lane the oldest ready window entry issues, so a younger ready entry issues ahead of an older entry that is not ready.
- R4: An entry is not ready while an older unissued non-branch entry writes one of its sources. It is also not ready while a floating-point instruction issued 1, 2 or 3 cycles earlier writes one of its sources. An integer result is therefore usable one cycle after its producer issues, and a floating-point result four cycles after.
- R5: A non-branch incoming instruction is refused, with `fetch_stall` high, while its destination equals that of any non-branch window entry (including one issuing in this cycle) or of a floating-point instruction issued 1 to 3 cycles earlier.
- R6: A non-branch entry is not ready while an older window entry reads its destination as either source.
- R7: While a branch sits in the window and does not issue in the current cycle, `fetch_stall` is high.
- R8: With all window entries occupied and none issuing, `fetch_stall` is high. A slot freed by an issue in a cycle can take the incoming instruction in that same cycle.
- R9: An accepted instruction can issue no earlier than the cycle after its acceptance.
- R10: When both lanes issue in one cycle, neither instruction reads the other's destination and their destinations differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch presents an instruction |
| in_cls | input | 2 | Class: 0 integer, 1 floating-point, 2 branch |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src1 | input | $clog2(NREG) | First source register |
| in_src2 | input | $clog2(NREG) | Second source register |
| fetch_stall | output | 1 | Fetch must hold; the presented instruction is not taken |
| int_valid | output | 1 | Integer lane issue this cycle |
| int_is_br | output | 1 | Issued integer-lane instruction is a branch |
| int_dst | output | $clog2(NREG) | Integer-lane destination |
| int_src1 | output | $clog2(NREG) | Integer-lane first source |
| int_src2 | output | $clog2(NREG) | Integer-lane second source |
| fp_valid | output | 1 | Floating-point lane issue this cycle |
| fp_dst | output | $clog2(NREG) | Floating-point destination |
| fp_src1 | output | $clog2(NREG) | Floating-point first source |
| fp_src2 | output | $clog2(NREG) | Floating-point second source |

## Verification
The properties rely on three assumptions about the inputs. Fetch keeps the class, destination and sources stable while `fetch_stall` holds it. Class code 3 never arrives. Both lanes take every issue without back-pressure.

The bench meets these assumptions by construction. It drives an instruction at the falling edge and leaves it untouched until a sample shows it was accepted. It draws classes only from 0 to 2. The lanes are modelled as always accepting, with the floating-point history kept from the issue outputs alone.

// File: rtl/iw_dispatch.sv
module iw_dispatch #(
  parameter int NENT    = 4,
  parameter int NREG    = 32,
  parameter int FP_HOLD = 3,
  localparam int RW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_cls,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src1,
  input  logic [RW-1:0] in_src2,
  output logic          fetch_stall,
  output logic          int_valid,
  output logic          int_is_br,
  output logic [RW-1:0] int_dst,
  output logic [RW-1:0] int_src1,
  output logic [RW-1:0] int_src2,
  output logic          fp_valid,
  output logic [RW-1:0] fp_dst,
  output logic [RW-1:0] fp_src1,
  output logic [RW-1:0] fp_src2
);
  localparam logic [1:0] CLS_FP = 2'd1;
  localparam logic [1:0] CLS_BR = 2'd2;

  logic [NENT-1:0] v_q;
  logic [1:0]      cls_q [NENT];
  logic [RW-1:0]   dst_q [NENT];
  logic [RW-1:0]   s1_q  [NENT];
  logic [RW-1:0]   s2_q  [NENT];
  logic [NENT-1:0] old_q [NENT];
  logic [FP_HOLD-1:0] fpv_q;
  logic [RW-1:0]      fpd_q [FP_HOLD];

  logic [NENT-1:0] is_fp, is_br, raw, war, rdy, g_int, g_fp, gnt, free, wr_oh;
  logic waw, full, br_wait, accept;

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      is_fp[i] = v_q[i] && (cls_q[i] == CLS_FP);
      is_br[i] = v_q[i] && (cls_q[i] == CLS_BR);
    end
  end

  always_comb begin
    raw = '0;
    war = '0;
    for (int i = 0; i < NENT; i++) begin
      for (int k = 0; k < FP_HOLD; k++)
        if (fpv_q[k] && (fpd_q[k] == s1_q[i] || fpd_q[k] == s2_q[i])) raw[i] = 1'b1;
      for (int j = 0; j < NENT; j++)
        if (v_q[j] && old_q[i][j]) begin
          if (cls_q[j] != CLS_BR && (dst_q[j] == s1_q[i] || dst_q[j] == s2_q[i])) raw[i] = 1'b1;
          if (cls_q[i] != CLS_BR && (s1_q[j] == dst_q[i] || s2_q[j] == dst_q[i])) war[i] = 1'b1;
        end
    end
  end

  assign rdy = v_q & ~raw & ~war;

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      g_fp[i]  = rdy[i] &  is_fp[i] & ~|(rdy &  is_fp & old_q[i]);
      g_int[i] = rdy[i] & ~is_fp[i] & ~|(rdy & ~is_fp & old_q[i]);
    end
  end

  assign gnt     = g_int | g_fp;
  assign free    = ~v_q | gnt;
  assign wr_oh   = free & (~free + NENT'(1));
  assign full    = ~|free;
  assign br_wait = |(is_br & ~g_int);

  always_comb begin
    waw = 1'b0;
    if (in_cls != CLS_BR) begin
      for (int i = 0; i < NENT; i++)
        if (v_q[i] && cls_q[i] != CLS_BR && dst_q[i] == in_dst) waw = 1'b1;
      for (int k = 0; k < FP_HOLD; k++)
        if (fpv_q[k] && fpd_q[k] == in_dst) waw = 1'b1;
    end
  end

  assign fetch_stall = full | br_wait | (in_valid & waw);
  assign accept      = in_valid & ~fetch_stall;

  always_comb begin
    int_valid = |g_int;
    fp_valid  = |g_fp;
    int_is_br = 1'b0;
    int_dst = '0; int_src1 = '0; int_src2 = '0;
    fp_dst  = '0; fp_src1  = '0; fp_src2  = '0;
    for (int i = 0; i < NENT; i++) begin
      if (g_int[i]) begin
        int_is_br = is_br[i];
        int_dst = dst_q[i]; int_src1 = s1_q[i]; int_src2 = s2_q[i];
      end
      if (g_fp[i]) begin
        fp_dst = dst_q[i]; fp_src1 = s1_q[i]; fp_src2 = s2_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      fpv_q <= '0;
      for (int k = 0; k < FP_HOLD; k++) fpd_q[k] <= '0;
      for (int i = 0; i < NENT; i++) begin
        cls_q[i] <= '0; dst_q[i] <= '0; s1_q[i] <= '0; s2_q[i] <= '0;
        old_q[i] <= '0;
      end
    end else begin
      v_q <= (v_q & ~gnt) | (accept ? wr_oh : '0);
      fpv_q[0] <= fp_valid;
      fpd_q[0] <= fp_dst;
      for (int k = 1; k < FP_HOLD; k++) begin
        fpv_q[k] <= fpv_q[k-1];
        fpd_q[k] <= fpd_q[k-1];
      end
      for (int i = 0; i < NENT; i++) begin
        if (accept && wr_oh[i]) begin
          cls_q[i] <= in_cls;
          dst_q[i] <= in_dst;
          s1_q[i]  <= in_src1;
          s2_q[i]  <= in_src2;
          old_q[i] <= v_q & ~gnt;
        end else if (accept) begin
          old_q[i] <= old_q[i] & ~wr_oh;
        end
      end
    end
  end
endmodule

module iw_dispatch_chk #(
  parameter int NENT    = 4,
  parameter int NREG    = 32,
  parameter int FP_HOLD = 3,
  localparam int RW     = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    in_cls,
  input logic [RW-1:0] in_dst,
  input logic [RW-1:0] in_src1,
  input logic [RW-1:0] in_src2,
  input logic          fetch_stall,
  input logic          int_valid,
  input logic          int_is_br,
  input logic [RW-1:0] int_dst,
  input logic [RW-1:0] int_src1,
  input logic [RW-1:0] int_src2,
  input logic          fp_valid,
  input logic [RW-1:0] fp_dst,
  input logic [RW-1:0] fp_src1,
  input logic [RW-1:0] fp_src2
);
  logic [FP_HOLD-1:0] hv;
  logic [RW-1:0]      hd [FP_HOLD];
  int occ;
  logic hit_int, hit_fp, hit_in, took;

  assign took = in_valid && !fetch_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv  <= '0;
      occ <= 0;
      for (int k = 0; k < FP_HOLD; k++) hd[k] <= '0;
    end else begin
      hv[0] <= fp_valid;
      hd[0] <= fp_dst;
      for (int k = 1; k < FP_HOLD; k++) begin
        hv[k] <= hv[k-1];
        hd[k] <= hd[k-1];
      end
      occ <= occ + int'(took) - int'(int_valid) - int'(fp_valid);
    end
  end

  always_comb begin
    hit_int = 1'b0; hit_fp = 1'b0; hit_in = 1'b0;
    for (int k = 0; k < FP_HOLD; k++) begin
      if (hv[k] && (hd[k] == int_src1 || hd[k] == int_src2)) hit_int = 1'b1;
      if (hv[k] && (hd[k] == fp_src1 || hd[k] == fp_src2)) hit_fp = 1'b1;
      if (hv[k] && hd[k] == in_dst) hit_in = 1'b1;
    end
  end

  p_fp_gap_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> !hit_int);
  p_fp_gap_fp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fp_valid |-> !hit_fp);
  p_waw_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_cls != 2'd2) |-> (!hit_in && !(fp_valid && fp_dst == in_dst)));
  p_branch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_cls == 2'd2) |=> (fetch_stall || (int_valid && int_is_br)));
  p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == NENT && !int_valid && !fp_valid) |-> fetch_stall);
  p_dual_indep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && fp_valid) |-> (fp_dst != int_src1 && fp_dst != int_src2 &&
      (int_is_br || (int_dst != fp_src1 && int_dst != fp_src2 && int_dst != fp_dst))));
endmodule

bind iw_dispatch iw_dispatch_chk #(.NENT(NENT), .NREG(NREG), .FP_HOLD(FP_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls), .in_dst(in_dst),
  .in_src1(in_src1), .in_src2(in_src2), .fetch_stall(fetch_stall),
  .int_valid(int_valid), .int_is_br(int_is_br), .int_dst(int_dst),
  .int_src1(int_src1), .int_src2(int_src2), .fp_valid(fp_valid),
  .fp_dst(fp_dst), .fp_src1(fp_src1), .fp_src2(fp_src2));

// File: tb/iw_dispatch_tb.sv
`timescale 1ns/1ps
module iw_dispatch_tb;
  localparam int NENT = 4;
  localparam int NREG = 32;
  localparam int RW = $clog2(NREG);
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_cls = '0;
  logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic fetch_stall, int_valid, int_is_br, fp_valid;
  logic [RW-1:0] int_dst, int_src1, int_src2, fp_dst, fp_src1, fp_src2;

  always #4 clk = ~clk;

  iw_dispatch #(.NENT(NENT), .NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls), .in_dst(in_dst),
    .in_src1(in_src1), .in_src2(in_src2), .fetch_stall(fetch_stall),
    .int_valid(int_valid), .int_is_br(int_is_br), .int_dst(int_dst),
    .int_src1(int_src1), .int_src2(int_src2), .fp_valid(fp_valid),
    .fp_dst(fp_dst), .fp_src1(fp_src1), .fp_src2(fp_src2));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int wc[$], wd[$], w1[$], w2[$];
  int fph[$];
  int acc_cyc[NREG], dint[NREG], dfp[NREG];
  int br_disp;
  bit acc;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // one cycle: sample after settling, compare against the queue model, advance the model
  task automatic step();
    int gi, gf, fd;
    bit e_stall, brw, waw, raw, war;
    #1;
    gi = -1; gf = -1;
    for (int i = 0; i < wc.size(); i++) begin
      raw = 0; war = 0;
      foreach (fph[k]) if (fph[k] >= 0 && (fph[k] == w1[i] || fph[k] == w2[i])) raw = 1;
      for (int j = 0; j < i; j++) begin
        if (wc[j] != 2 && (wd[j] == w1[i] || wd[j] == w2[i])) raw = 1;
        if (wc[i] != 2 && (w1[j] == wd[i] || w2[j] == wd[i])) war = 1;
      end
      if (!raw && !war) begin
        if (wc[i] == 1) begin if (gf < 0) gf = i; end
        else if (gi < 0) gi = i;
      end
    end
    brw = 0;
    for (int i = 0; i < wc.size(); i++) if (wc[i] == 2 && i != gi) brw = 1;
    waw = 0;
    if (in_cls != 2) begin
      for (int i = 0; i < wc.size(); i++) if (wc[i] != 2 && wd[i] == int'(in_dst)) waw = 1;
      foreach (fph[k]) if (fph[k] == int'(in_dst)) waw = 1;
    end
    e_stall = (wc.size() - int'(gi >= 0) - int'(gf >= 0) >= NENT) || brw || (in_valid && waw);
    check("R5 R7 R8 fetch_stall", int'(fetch_stall), int'(e_stall));
    check("R3 R4 R6 int_valid", int'(int_valid), int'(gi >= 0));
    check("R3 R4 R6 fp_valid", int'(fp_valid), int'(gf >= 0));
    if (gi >= 0 && int_valid) begin
      check("R2 int_is_br", int'(int_is_br), int'(wc[gi] == 2));
      check("R2 int_src1", int'(int_src1), w1[gi]);
      check("R2 int_src2", int'(int_src2), w2[gi]);
      if (wc[gi] != 2) check("R2 int_dst", int'(int_dst), wd[gi]);
    end
    if (gf >= 0 && fp_valid) begin
      check("R2 fp_dst", int'(fp_dst), wd[gf]);
      check("R2 fp_src1", int'(fp_src1), w1[gf]);
      check("R2 fp_src2", int'(fp_src2), w2[gf]);
    end
    if (int_valid) begin
      if (int_is_br) br_disp = cyc; else dint[int_dst] = cyc;
    end
    if (fp_valid) dfp[fp_dst] = cyc;
    acc = in_valid && !fetch_stall;
    if (acc) acc_cyc[in_dst] = cyc;
    fd = (gf >= 0) ? wd[gf] : -1;
    @(posedge clk);
    if (gi > gf) begin
      wc.delete(gi); wd.delete(gi); w1.delete(gi); w2.delete(gi);
      if (gf >= 0) begin wc.delete(gf); wd.delete(gf); w1.delete(gf); w2.delete(gf); end
    end else if (gf >= 0) begin
      wc.delete(gf); wd.delete(gf); w1.delete(gf); w2.delete(gf);
      if (gi >= 0) begin wc.delete(gi); wd.delete(gi); w1.delete(gi); w2.delete(gi); end
    end
    if (in_valid && !e_stall) begin
      wc.push_back(int'(in_cls)); wd.push_back(int'(in_dst));
      w1.push_back(int'(in_src1)); w2.push_back(int'(in_src2));
    end
    fph.push_front(fd);
    void'(fph.pop_back());
    @(negedge clk);
    cyc++;
    if (cyc > LIMIT) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
      finish_run();
    end
  endtask

  task automatic issue(int c, int d, int a, int b);
    in_valid = 1'b1; in_cls = 2'(c); in_dst = RW'(d); in_src1 = RW'(a); in_src2 = RW'(b);
    do step(); while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    fph = '{-1, -1, -1};
    br_disp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset fetch_stall", int'(fetch_stall), 0);
    check("R1 reset int_valid", int'(int_valid), 0);
    check("R1 reset fp_valid", int'(fp_valid), 0);
    @(negedge clk);

    // R9 and R4: integer back-to-back, floating-point four-cycle gap
    issue(0, 12, 1, 1); issue(0, 13, 12, 12); idle(6);
    check("R9 issue after accept", dint[12] - acc_cyc[12], 1);
    check("R4 int dependent gap", dint[13] - dint[12], 1);
    issue(1, 8, 1, 1); issue(1, 11, 8, 8); idle(8);
    check("R4 fp dependent gap", dfp[11] - dfp[8], 4);

    // R10 and R2: two consumers released together go out on both lanes
    issue(1, 8, 1, 2); issue(0, 9, 8, 1); issue(1, 10, 8, 3); idle(8);
    check("R10 dual issue same cycle", dint[9], dfp[10]);
    check("R2 fp class on fp lane", dfp[10] - dfp[8], 4);

    // R3: younger independent bypasses older stalled
    issue(1, 20, 1, 1); issue(0, 21, 20, 1); issue(0, 22, 2, 2); idle(8);
    check("R3 younger passes older", int'(dint[22] < dint[21]), 1);

    // R5: WAW against floating-point stages
    issue(1, 24, 1, 1); issue(0, 24, 2, 2); idle(8);
    check("R5 waw release cycle", acc_cyc[24] - dfp[24], 4);

    // R6: WAR writer waits for older reader
    issue(1, 30, 1, 1); issue(0, 31, 30, 2); issue(0, 2, 3, 3); idle(8);
    check("R6 war writer after reader", dint[2] - dint[31], 1);

    // R7: branch freezes fetch until it issues
    issue(1, 5, 1, 1); issue(2, 0, 5, 5); issue(0, 6, 1, 1); idle(8);
    check("R7 fetch resumes at branch issue", acc_cyc[6], br_disp);

    // R8: full window, freed slot reused in the same cycle
    issue(1, 10, 1, 1); issue(1, 16, 10, 10);
    issue(0, 11, 16, 1); issue(0, 12, 16, 1); issue(0, 13, 16, 1); issue(0, 14, 16, 1);
    issue(0, 15, 2, 2); idle(10);
    check("R8 accept in freeing cycle", acc_cyc[15], dint[11]);
    check("R8 stalled while full", acc_cyc[15] - acc_cyc[14], 4);

    // mixed traffic on a small register set
    for (int n = 0; n < 1500; n++) begin
      int c;
      c = int'($urandom % 7);
      c = (c < 3) ? 0 : (c < 6) ? 1 : 2;
      issue(c, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
      if ($urandom % 4 == 0) idle(int'($urandom % 3));
    end
    idle(12);
    check("R1 drained int_valid", int'(int_valid), 0);
    check("R1 drained fetch_stall", int'(fetch_stall), 0);
    finish_run();
  end
endmodule